// File: doc/BRIEF.md
# Open-Page Tracking Table

This block remembers, for every bank of every DRAM row, whether a page is open and which page address it holds. An arbiter gives it the row, bank and page address of the next request. One clock later it gets back a classification. A hit means the open page matches. A miss means another page is open, so the controller must precharge and then activate. Idle means no page is open, so an activate alone is enough. Because the lookup is registered and is separate from the update port, the arbiter can classify its next request while the current DRAM access is still running.

The controller reports each activate and precharge on the update port. A single close-all strobe, used around refresh, shuts every page at once. The table never closes a page because DRAM ownership moved from one master to another. Any number of rows, up to all of them, may hold open pages at the same time. Each row is configured by one bit to track either four banks or two.

Top module: `open_page_table`

## Requirements
- R1: When `lk_en` is high in cycle N, `res_valid` is high in cycle N+1 and `res_kind` carries that lookup's result. When `lk_en` is low, `res_valid` and `res_kind` are both 0 in the next cycle.
- R2: An activate update (`upd_en`=1, `upd_open`=1) opens the addressed bank and stores `upd_page`. A later lookup of that bank with the same page returns hit, encoded as `res_kind`=2'b01.
- R3: A lookup of an open bank with a different page address returns miss, encoded as `res_kind`=2'b10.
- R4: A lookup of a bank with no open page returns idle, encoded as `res_kind`=2'b00. The value 2'b11 never appears.
- R5: A precharge update (`upd_en`=1, `upd_open`=0) closes the addressed bank.
- R6: An update and a lookup in the same cycle to the same bank are classified against the state after the update.
- R7: `close_all` closes every bank of every row in one clock. It takes priority over an update in the same cycle, and a lookup in that cycle sees every bank closed.
- R8: Reset closes every bank and drives `res_valid` low.
- R9: In a row whose `row_four_bank` bit is 0, bank indices 2 and 3 are out of range. Updates to them are ignored, and lookups of them return idle.
- R10: Updates to one bank leave all other banks unchanged. Pages in every row may be open at the same time, and none of them closes without a precharge, a close-all or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_four_bank | input | NUM_ROWS | Per row: 1 = four banks tracked, 0 = two |
| close_all | input | 1 | Close every page (refresh) |
| upd_en | input | 1 | Update strobe |
| upd_open | input | 1 | 1 = activate, 0 = precharge |
| upd_row | input | ROW_W | Update row |
| upd_bank | input | BANK_W | Update bank |
| upd_page | input | PAGE_W | Page address opened by an activate |
| lk_en | input | 1 | Lookup strobe |
| lk_row | input | ROW_W | Lookup row |
| lk_bank | input | BANK_W | Lookup bank |
| lk_page | input | PAGE_W | Lookup page address |
| res_valid | output | 1 | Lookup result valid, one cycle after `lk_en` |
| res_kind | output | 2 | 00 idle, 01 hit, 10 miss |

## Verification
The bench uses the default build: four rows of up to four banks and 12-bit page addresses. It sets the row configuration to 4'b0101, so rows 0 and 2 track four banks and rows 1 and 3 track two, and both the full and the narrow row paths are exercised side by side. The random phase draws page addresses from a set of only four values. This makes hits, misses and idles all frequent, and it makes same-cycle collisions between updates, lookups and close-all common.

// File: rtl/opt_pkg.sv
package opt_pkg;
    typedef enum logic [1:0] {
        PG_IDLE = 2'b00,
        PG_HIT  = 2'b01,
        PG_MISS = 2'b10
    } pg_kind_e;
endpackage

// File: rtl/opt_row.sv
module opt_row #(
    parameter int BANKS  = 4,
    parameter int PAGE_W = 12,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           four_bank,
    input  logic                           close_all,
    input  logic                           upd_hit,
    input  logic                           upd_open,
    input  logic [BANK_W-1:0]              upd_bank,
    input  logic [PAGE_W-1:0]              upd_page,
    output logic [BANKS-1:0]               vld_nx,
    output logic [BANKS-1:0][PAGE_W-1:0]   pg_nx
);
    localparam logic [BANK_W-1:0] HALF_IDX = BANK_W'(BANKS / 2);

    typedef struct packed {
        logic [BANKS-1:0]             vld;
        logic [BANKS-1:0][PAGE_W-1:0] pg;
    } row_st_t;

    row_st_t st_d, st_q;
    logic    in_range;

    assign in_range = four_bank || (upd_bank < HALF_IDX);

    always_comb begin
        st_d = st_q;
        if (close_all) begin
            st_d.vld = '0;
        end else if (upd_hit && in_range) begin
            if (upd_open) begin
                st_d.vld[upd_bank] = 1'b1;
                st_d.pg[upd_bank]  = upd_page;
            end else begin
                st_d.vld[upd_bank] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_nx = st_d.vld;
    assign pg_nx  = st_d.pg;

    // R2
    activate_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit && upd_open && in_range && !close_all
        |=> st_q.vld[$past(upd_bank)] && st_q.pg[$past(upd_bank)] == $past(upd_page));

    // R5
    precharge_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit && !upd_open && in_range && !close_all
        |=> !st_q.vld[$past(upd_bank)]);

    // R7
    close_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_all |=> st_q.vld == '0);

    // R9
    narrow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit && !four_bank && upd_bank >= HALF_IDX && !close_all |=> $stable(st_q));
endmodule

// File: rtl/opt_classify.sv
module opt_classify
    import opt_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input  logic              is_open,
    input  logic              in_range,
    input  logic [PAGE_W-1:0] page_held,
    input  logic [PAGE_W-1:0] page_req,
    output pg_kind_e          kind
);
    always_comb begin
        if (!in_range || !is_open)     kind = PG_IDLE;
        else if (page_held == page_req) kind = PG_HIT;
        else                           kind = PG_MISS;
    end
endmodule

// File: rtl/open_page_table.sv
module open_page_table
    import opt_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    parameter int BANKS    = 4,
    parameter int PAGE_W   = 12,
    localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_four_bank,
    input  logic                close_all,
    input  logic                upd_en,
    input  logic                upd_open,
    input  logic [ROW_W-1:0]    upd_row,
    input  logic [BANK_W-1:0]   upd_bank,
    input  logic [PAGE_W-1:0]   upd_page,
    input  logic                lk_en,
    input  logic [ROW_W-1:0]    lk_row,
    input  logic [BANK_W-1:0]   lk_bank,
    input  logic [PAGE_W-1:0]   lk_page,
    output logic                res_valid,
    output logic [1:0]          res_kind
);
    localparam logic [BANK_W-1:0] HALF_IDX = BANK_W'(BANKS / 2);

    typedef struct packed {
        logic     valid;
        pg_kind_e kind;
    } res_st_t;

    logic [NUM_ROWS-1:0][BANKS-1:0]             row_vld;
    logic [NUM_ROWS-1:0][BANKS-1:0][PAGE_W-1:0] row_pg;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        opt_row #(.BANKS(BANKS), .PAGE_W(PAGE_W)) i_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .four_bank(row_four_bank[r]),
            .close_all(close_all),
            .upd_hit  (upd_en && (upd_row == ROW_W'(r))),
            .upd_open (upd_open),
            .upd_bank (upd_bank),
            .upd_page (upd_page),
            .vld_nx   (row_vld[r]),
            .pg_nx    (row_pg[r])
        );
    end

    logic     lk_in_range;
    pg_kind_e lk_kind;
    res_st_t  res_d, res_q;

    assign lk_in_range = row_four_bank[lk_row] || (lk_bank < HALF_IDX);

    opt_classify #(.PAGE_W(PAGE_W)) i_classify (
        .is_open  (row_vld[lk_row][lk_bank]),
        .in_range (lk_in_range),
        .page_held(row_pg[lk_row][lk_bank]),
        .page_req (lk_page),
        .kind     (lk_kind)
    );

    always_comb begin
        res_d.valid = lk_en;
        res_d.kind  = lk_en ? lk_kind : PG_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '{valid: 1'b0, kind: PG_IDLE};
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_kind  = res_q.kind;

    // R1
    result_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> res_valid);

    // R1
    result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> !res_valid && res_kind == 2'b00);

    // R4
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_kind != 2'b11);

    // R7
    close_lookup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_all && lk_en |=> res_kind == 2'b00);
endmodule

// File: tb/test_open_page_table.sv
module test_open_page_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  row_four_bank = 4'b0101;
    logic        close_all = 1'b0;
    logic        upd_en = 1'b0, upd_open = 1'b0;
    logic [1:0]  upd_row = '0, upd_bank = '0;
    logic [11:0] upd_page = '0;
    logic        lk_en = 1'b0;
    logic [1:0]  lk_row = '0, lk_bank = '0;
    logic [11:0] lk_page = '0;
    logic        res_valid;
    logic [1:0]  res_kind;

    always #2 clk = ~clk;

    open_page_table i_open_page_table (
        .clk(clk), .rst_n(rst_n), .row_four_bank(row_four_bank), .close_all(close_all),
        .upd_en(upd_en), .upd_open(upd_open), .upd_row(upd_row), .upd_bank(upd_bank),
        .upd_page(upd_page), .lk_en(lk_en), .lk_row(lk_row), .lk_bank(lk_bank),
        .lk_page(lk_page), .res_valid(res_valid), .res_kind(res_kind)
    );

    int n_run = 0, n_fail = 0;
    bit         m_open [4][4];
    int         m_page [4][4];
    logic       pend_v = 1'b0;
    logic [1:0] pend_k = 2'b00;
    string      pend_tag = "R8";
    bit         done = 1'b0;

    task automatic check_out();
        n_run++;
        if (res_valid !== pend_v || res_kind !== (pend_v ? pend_k : 2'b00)) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b kind=%0d, expected valid=%0b kind=%0d",
                     pend_tag, res_valid, res_kind, pend_v, pend_v ? pend_k : 2'b00);
        end
    endtask

    task automatic step(input bit lv, input int lr, input int lb, input int lp,
                        input bit uv, input bit uo, input int ur, input int ub, input int up,
                        input bit ca, input string tag);
        @(negedge clk);
        check_out();
        lk_en = lv; lk_row = 2'(lr); lk_bank = 2'(lb); lk_page = 12'(lp);
        upd_en = uv; upd_open = uo; upd_row = 2'(ur); upd_bank = 2'(ub); upd_page = 12'(up);
        close_all = ca;
        // reference: state after this cycle's update, then classify
        if (ca) begin
            for (int r = 0; r < 4; r++) for (int b = 0; b < 4; b++) m_open[r][b] = 1'b0;
        end else if (uv && (row_four_bank[ur] || ub < 2)) begin
            m_open[ur][ub] = uo;
            if (uo) m_page[ur][ub] = up;
        end
        pend_v = lv;
        if (!(row_four_bank[lr] || lb < 2) || !m_open[lr][lb]) pend_k = 2'b00;
        else if (m_page[lr][lb] == lp)                         pend_k = 2'b01;
        else                                                    pend_k = 2'b10;
        if (tag != "") pend_tag = tag;
        else if (!lv)  pend_tag = "R1";
        else           pend_tag = (pend_k == 2'b01) ? "R2" : (pend_k == 2'b10) ? "R3" : "R4";
    endtask

    initial begin
        for (int r = 0; r < 4; r++) for (int b = 0; b < 4; b++) begin
            m_open[r][b] = 1'b0; m_page[r][b] = 0;
        end
        repeat (3) @(negedge clk);
        pend_tag = "R8";
        check_out();                                        // R8 reset state
        rst_n = 1'b1;
        step(1, 0, 1, 5,  0, 0, 0, 0, 0,  0, "R8");        // nothing open after reset
        step(1, 0, 1, 5,  1, 1, 0, 1, 5,  0, "R6");        // bypass: activate seen same cycle
        step(1, 0, 1, 5,  0, 0, 0, 0, 0,  0, "R2");
        step(1, 0, 1, 6,  0, 0, 0, 0, 0,  0, "R3");
        step(1, 1, 0, 3,  1, 1, 3, 0, 7,  0, "R4");
        step(0, 0, 0, 0,  1, 1, 1, 0, 1,  0, "R1");
        step(0, 0, 0, 0,  1, 1, 2, 3, 2,  0, "R1");
        step(1, 3, 0, 7,  0, 0, 0, 0, 0,  0, "R10");       // every row holds a page
        step(1, 0, 1, 5,  0, 0, 0, 0, 0,  0, "R10");
        step(1, 1, 2, 9,  1, 1, 1, 2, 9,  0, "R9");        // narrow row, bank 2 ignored
        step(1, 1, 2, 9,  0, 0, 0, 0, 0,  0, "R9");
        step(1, 1, 0, 1,  0, 0, 0, 0, 0,  0, "R9");
        step(1, 0, 1, 5,  1, 0, 0, 1, 0,  0, "R6");        // precharge seen same cycle
        step(1, 0, 1, 5,  0, 0, 0, 0, 0,  0, "R5");
        step(1, 2, 3, 2,  0, 0, 0, 0, 0,  0, "R10");
        step(1, 2, 3, 2,  1, 1, 0, 0, 3,  1, "R7");        // close_all beats activate
        step(1, 0, 0, 3,  0, 0, 0, 0, 0,  0, "R7");
        step(1, 3, 0, 7,  0, 0, 0, 0, 0,  0, "R7");
        step(0, 0, 0, 0,  0, 0, 0, 0, 0,  0, "R1");
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 3),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 63) == 0, "");
        end
        @(negedge clk);
        check_out();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule